// File: doc/BRIEF.md
# Self-Timed Program/Erase and Low-Power Sequencer

This block runs the back half of a serial memory's write path. A command front end decodes opcodes while chip select is low and hands this block one-cycle pulses. Each pulse marks a page program, a sector erase, a block erase, a deep power-down entry or a wake-up request. The sequencer holds the request and acts only when chip select returns high. At that point it either starts a timed array operation or changes power state.

A timed operation raises a busy flag for a fixed, parameterised number of clock cycles. In its first cycle it emits one strobe to the array, together with the inclusive address range the strobe covers. Program acts on one 256-byte page. Sector erase acts on 4 KiB and block erase on 64 KiB; erasing sets every bit in the range to one. In deep power-down the block tells the front end, through a command gate, to stop accepting everything except wake-up. Wake-up is followed by a recovery interval, during which nothing is accepted. A power-good input stands in for supply monitoring. While it is low the sequencer is held idle, and after it rises, write-type commands are refused for a set delay.

Top module: `sq_seq_top`

## Requirements
- R1: On the first clock edge that sees `cs_n` high after a frame holding an accepted program or erase pulse, `busy` rises. In that same cycle exactly one of `prog_stb` (program) or `erase_stb` (sector or block erase) is high, for one cycle only.
- R2: `busy` stays high for exactly PP_CYC cycles after a program, SE_CYC after a sector erase and BE_CYC after a block erase. It then returns low.
- R3: For a program, `rng_lo` is the address with bits 7:0 cleared and `rng_hi` is the address with bits 7:0 set (a 256-byte page).
- R4: For a sector erase, bits 16:12 of the address pick one of 32 sectors. `rng_lo` has bits 11:0 cleared and `rng_hi` has bits 11:0 set.
- R5: For a block erase, bit 16 picks one of 2 blocks. `rng_lo` has bits 15:0 cleared and `rng_hi` has bits 15:0 set.
- R6: While `pwr_good` is low, the sequencer is idle and `busy` and `deep_pd` are low. Program and erase pulses are ignored until PUW_CYC cycles of `pwr_good` high have passed.
- R7: A program or erase whose `allow` is low at the chip-select rise is dropped. `busy` stays low and no strobe is issued.
- R8: Program, erase and power-down pulses that arrive while `busy` is high are ignored. They neither extend nor restart the operation.
- R9: A power-down pulse (entry opcode B9h, decoded upstream) takes effect at the chip-select rise, and only when no operation is in progress. `deep_pd` then rises.
- R10: While `deep_pd` is high, `cmd_gate` is low and every pulse except wake-up (opcode ABh) is ignored.
- R11: A wake-up pulse in deep power-down clears `deep_pd` at the chip-select rise. `cmd_gate` then stays low for exactly RES_CYC cycles, and pulses arriving in that interval are ignored.
- R12: Out of reset, `busy`, `deep_pd`, `prog_stb` and `erase_stb` are low and `cmd_gate` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply is valid |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| cmd_pp | input | 1 | Page program pulse (given after at least one data byte) |
| cmd_se | input | 1 | Sector erase pulse |
| cmd_be | input | 1 | Block erase pulse |
| cmd_dp | input | 1 | Deep power-down entry pulse |
| cmd_rdp | input | 1 | Wake-up pulse |
| addr | input | ADDR_W | Address captured with a program or erase pulse |
| allow | input | 1 | Protection logic permits the pending operation |
| busy | output | 1 | Self-timed operation in progress |
| deep_pd | output | 1 | Deep power-down state |
| cmd_gate | output | 1 | Front end may accept all opcodes |
| prog_stb | output | 1 | One-cycle page write strobe |
| erase_stb | output | 1 | One-cycle range erase strobe |
| rng_lo | output | ADDR_W | First address of the affected range |
| rng_hi | output | ADDR_W | Last address of the affected range |

## Verification
If the state register or the pending-operation register is corrupted, the fault is visible at the ports on the cycle after the chip-select rise. The result can be a missing or doubled strobe, a busy flag that should not be there, or a wrong range width. A count-down error only shows when `busy` or the gate's blocked interval ends early or late. Because of that, the bench counts these intervals to the exact cycle rather than sampling them once. A fault in the power-up timer is visible only as a program that is accepted too early or refused too late.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_PP, OP_SE, OP_BE, OP_DP, OP_RDP
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_BUSY, ST_DPD, ST_RECOV
  } st_e;
endpackage

// File: rtl/sq_pwr_timer.sv
module sq_pwr_timer #(
  parameter int PUW_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic ready
);
  localparam int W = $clog2(PUW_CYC + 1);
  localparam logic [W-1:0] LIMIT = W'(PUW_CYC);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pwr_good) cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = pwr_good && (cnt_q == LIMIT);
endmodule

// File: rtl/sq_cs_edge.sv
module sq_cs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic rise
);
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign rise = cs_n && !cs_q;
endmodule

// File: rtl/sq_range.sv
module sq_range
  import sq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi
);
  localparam logic [ADDR_W-1:0] ONES  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] M_PG  = ONES >> (ADDR_W - PAGE_W);
  localparam logic [ADDR_W-1:0] M_SEC = ONES >> (ADDR_W - SECT_W);
  localparam logic [ADDR_W-1:0] M_BLK = ONES >> (ADDR_W - BLK_W);

  logic [ADDR_W-1:0] mask;

  always_comb begin
    case (op)
      OP_SE:   mask = M_SEC;
      OP_BE:   mask = M_BLK;
      default: mask = M_PG;
    endcase
    lo = addr & ~mask;
    hi = addr | mask;
  end
endmodule

// File: rtl/sq_seq_top.sv
module sq_seq_top
  import sq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int PAGE_W  = 8,
  parameter int SECT_W  = 12,
  parameter int BLK_W   = 16,
  parameter int PP_CYC  = 20,
  parameter int SE_CYC  = 40,
  parameter int BE_CYC  = 60,
  parameter int RES_CYC = 8,
  parameter int PUW_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              cs_n,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic              cmd_dp,
  input  logic              cmd_rdp,
  input  logic [ADDR_W-1:0] addr,
  input  logic              allow,
  output logic              busy,
  output logic              deep_pd,
  output logic              cmd_gate,
  output logic              prog_stb,
  output logic              erase_stb,
  output logic [ADDR_W-1:0] rng_lo,
  output logic [ADDR_W-1:0] rng_hi
);
  localparam int MAX_A = (PP_CYC > SE_CYC) ? PP_CYC : SE_CYC;
  localparam int MAX_B = (BE_CYC > RES_CYC) ? BE_CYC : RES_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic ready, cs_rise;
  st_e  st_q, st_d;
  op_e  pend_q, pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic [ADDR_W-1:0] lo_q, lo_d, hi_q, hi_d, r_lo, r_hi;
  logic pstb_q, pstb_d, estb_q, estb_d;
  logic [CNT_W-1:0]  dur;

  sq_pwr_timer #(.PUW_CYC(PUW_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ready(ready)
  );

  sq_cs_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(cs_rise)
  );

  sq_range #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W), .BLK_W(BLK_W)
  ) u_range (
    .op(pend_q), .addr(paddr_q), .lo(r_lo), .hi(r_hi)
  );

  always_comb begin
    case (pend_q)
      OP_SE:   dur = CNT_W'(SE_CYC - 1);
      OP_BE:   dur = CNT_W'(BE_CYC - 1);
      default: dur = CNT_W'(PP_CYC - 1);
    endcase
  end

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    paddr_d = paddr_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    pstb_d  = 1'b0;
    estb_d  = 1'b0;

    // capture decoded pulses inside the frame
    if (!cs_n) begin
      if (st_q == ST_IDLE) begin
        if (ready && cmd_pp)      begin pend_d = OP_PP; paddr_d = addr; end
        else if (ready && cmd_se) begin pend_d = OP_SE; paddr_d = addr; end
        else if (ready && cmd_be) begin pend_d = OP_BE; paddr_d = addr; end
        else if (cmd_dp)          pend_d = OP_DP;
      end else if (st_q == ST_DPD && cmd_rdp) begin
        pend_d = OP_RDP;
      end
    end

    // act at the end of the frame
    if (cs_rise) begin
      pend_d = OP_NONE;
      if (st_q == ST_IDLE) begin
        if (pend_q == OP_PP || pend_q == OP_SE || pend_q == OP_BE) begin
          if (allow) begin
            st_d   = ST_BUSY;
            cnt_d  = dur;
            lo_d   = r_lo;
            hi_d   = r_hi;
            pstb_d = (pend_q == OP_PP);
            estb_d = (pend_q != OP_PP);
          end
        end else if (pend_q == OP_DP) begin
          st_d = ST_DPD;
        end
      end else if (st_q == ST_DPD && pend_q == OP_RDP) begin
        st_d  = ST_RECOV;
        cnt_d = CNT_W'(RES_CYC - 1);
      end
    end

    // timed states count down
    if (st_q == ST_BUSY || st_q == ST_RECOV) begin
      if (cnt_q == '0) st_d  = ST_IDLE;
      else             cnt_d = cnt_q - 1'b1;
    end

    if (!pwr_good) begin
      st_d   = ST_IDLE;
      pend_d = OP_NONE;
      cnt_d  = '0;
      pstb_d = 1'b0;
      estb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pend_q  <= OP_NONE;
      cnt_q   <= '0;
      paddr_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      pstb_q  <= 1'b0;
      estb_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      paddr_q <= paddr_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      pstb_q  <= pstb_d;
      estb_q  <= estb_d;
    end
  end

  assign busy      = (st_q == ST_BUSY);
  assign deep_pd   = (st_q == ST_DPD);
  assign cmd_gate  = (st_q == ST_IDLE) || (st_q == ST_BUSY);
  assign prog_stb  = pstb_q;
  assign erase_stb = estb_q;
  assign rng_lo    = lo_q;
  assign rng_hi    = hi_q;
endmodule

// File: rtl/sq_seq_chk.sv
module sq_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8,
  parameter int BE_CYC = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              cs_n,
  input logic              busy,
  input logic              deep_pd,
  input logic              cmd_gate,
  input logic              prog_stb,
  input logic              erase_stb,
  input logic [ADDR_W-1:0] rng_lo,
  input logic [ADDR_W-1:0] rng_hi
);
  localparam int RW = $clog2(BE_CYC + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_q <= '0;
    else if (!busy)           run_q <= '0;
    else if (run_q != RW'(BE_CYC + 1)) run_q <= run_q + 1'b1;
  end

  p_rise_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (prog_stb || erase_stb));
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, erase_stb}));
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb || erase_stb) |=> !(prog_stb || erase_stb));
  p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RW'(BE_CYC)));
  p_page_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> ((rng_hi - rng_lo) == ADDR_W'((1 << PAGE_W) - 1)));
  p_pwr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!busy && !deep_pd));
  p_dpd_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_pd) |-> ($past(cs_n) && !$past(busy)));
  p_dpd_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    deep_pd |-> !cmd_gate);
  p_wake_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && $fell(deep_pd)) |-> !cmd_gate);
endmodule

bind sq_seq_top sq_seq_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BE_CYC(BE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_n(cs_n),
  .busy(busy), .deep_pd(deep_pd), .cmd_gate(cmd_gate),
  .prog_stb(prog_stb), .erase_stb(erase_stb),
  .rng_lo(rng_lo), .rng_hi(rng_hi)
);

// File: tb/tb_sq_seq_top.sv
`timescale 1ns/1ps
module tb_sq_seq_top;
  localparam int AW = 17, PP = 20, SE = 40, BE = 60, RES = 8, PUW = 16;

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0, cs_n = 1'b1;
  logic cmd_pp = 0, cmd_se = 0, cmd_be = 0, cmd_dp = 0, cmd_rdp = 0;
  logic [AW-1:0] addr = '0;
  logic allow = 1'b1;
  logic busy, deep_pd, cmd_gate, prog_stb, erase_stb;
  logic [AW-1:0] rng_lo, rng_hi;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  sq_seq_top #(.PP_CYC(PP), .SE_CYC(SE), .BE_CYC(BE), .RES_CYC(RES), .PUW_CYC(PUW)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_n(cs_n),
    .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be), .cmd_dp(cmd_dp),
    .cmd_rdp(cmd_rdp), .addr(addr), .allow(allow), .busy(busy),
    .deep_pd(deep_pd), .cmd_gate(cmd_gate), .prog_stb(prog_stb),
    .erase_stb(erase_stb), .rng_lo(rng_lo), .rng_hi(rng_hi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 1 pp, 2 se, 3 be, 4 dp, 5 rdp; returns at the negedge after launch
  task automatic frame(input int kind, input logic [AW-1:0] a, input bit al);
    @(negedge clk);
    cs_n = 0; addr = a; allow = al;
    cmd_pp = (kind == 1); cmd_se = (kind == 2); cmd_be = (kind == 3);
    cmd_dp = (kind == 4); cmd_rdp = (kind == 5);
    @(negedge clk);
    {cmd_pp, cmd_se, cmd_be, cmd_dp, cmd_rdp} = '0;
    cs_n = 1;
    @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic gate_low_len(output int n);
    n = 0;
    while (!cmd_gate && n < 1000) begin n++; @(negedge clk); end
  endtask

  // launch and check one operation fully
  task automatic op_check(input int kind, input logic [AW-1:0] a, input string req);
    int n, w, cyc;
    logic [AW-1:0] m;
    w   = (kind == 1) ? 8 : (kind == 2) ? 12 : 16;
    cyc = (kind == 1) ? PP : (kind == 2) ? SE : BE;
    m   = AW'((1 << w) - 1);
    frame(kind, a, 1'b1);
    chk(busy === 1'b1, {req, " R1 busy"}, busy, 1);
    chk((kind == 1) ? (prog_stb === 1 && erase_stb === 0) : (prog_stb === 0 && erase_stb === 1),
        {req, " R1 strobe"}, {prog_stb, erase_stb}, (kind == 1) ? 2 : 1);
    chk(rng_lo === (a & ~m), {req, " lo"}, rng_lo, a & ~m);
    chk(rng_hi === (a | m), {req, " hi"}, rng_hi, a | m);
    @(negedge clk);
    chk(prog_stb === 0 && erase_stb === 0, "R1 strobe single", {prog_stb, erase_stb}, 0);
    busy_len(n);
    chk(n + 1 == cyc, "R2 busy length", n + 1, cyc);
  endtask

  initial begin
    int n;
    #1;
    @(negedge clk);
    chk(busy === 0 && deep_pd === 0 && prog_stb === 0 && erase_stb === 0 && cmd_gate === 1,
        "R12 reset", {busy, deep_pd, prog_stb, erase_stb, cmd_gate}, 1);
    rst_n = 1;
    pwr_good = 1;
    // R6: too early after power-good
    frame(1, 17'h00100, 1'b1);
    chk(busy === 0 && prog_stb === 0, "R6 early program ignored", busy, 0);
    repeat (PUW + 4) @(negedge clk);
    chk(busy === 0, "R6 still idle", busy, 0);

    // R3: pages
    for (int p = 0; p < 512; p += 37) op_check(1, AW'(p * 256 + (p % 256)), "R3");
    // R4: every sector
    for (int s = 0; s < 32; s++) op_check(2, AW'(s * 4096 + s * 100 + 5), "R4");
    // R5: both blocks
    for (int b = 0; b < 2; b++) op_check(3, AW'(b * 65536 + 12345), "R5");

    // R7: disallowed
    frame(2, 17'h03000, 1'b0);
    chk(busy === 0 && erase_stb === 0, "R7 dropped", {busy, erase_stb}, 0);
    repeat (3) @(negedge clk);
    chk(busy === 0, "R7 stays idle", busy, 0);

    // R8: commands during busy
    frame(2, 17'h05000, 1'b1);
    frame(3, 17'h10000, 1'b1);
    busy_len(n);
    chk(n == SE - 3, "R8 busy not extended", n, SE - 3);
    repeat (3) @(negedge clk);
    chk(busy === 0 && erase_stb === 0, "R8 no relaunch", busy, 0);
    frame(1, 17'h00200, 1'b1);
    frame(4, '0, 1'b1);
    busy_len(n);
    repeat (2) @(negedge clk);
    chk(deep_pd === 0, "R8 R9 power-down during busy ignored", deep_pd, 0);

    // R9/R10
    frame(4, '0, 1'b1);
    chk(deep_pd === 1 && cmd_gate === 0, "R9 enter deep power-down", {deep_pd, cmd_gate}, 2);
    frame(1, 17'h00300, 1'b1);
    chk(busy === 0 && deep_pd === 1, "R10 program ignored", {busy, deep_pd}, 1);
    frame(2, 17'h00300, 1'b1);
    chk(busy === 0 && deep_pd === 1 && cmd_gate === 0, "R10 erase ignored", {busy, deep_pd}, 1);

    // R11: wake-up and recovery
    frame(5, '0, 1'b1);
    chk(deep_pd === 0 && cmd_gate === 0, "R11 wake", {deep_pd, cmd_gate}, 0);
    gate_low_len(n);
    chk(n == RES, "R11 recovery length", n, RES);
    chk(cmd_gate === 1, "R11 gate reopened", cmd_gate, 1);
    frame(4, '0, 1'b1);
    frame(5, '0, 1'b1);
    frame(1, 17'h00400, 1'b1);
    chk(busy === 0, "R11 program in recovery ignored", busy, 0);
    gate_low_len(n);
    repeat (2) @(negedge clk);
    chk(busy === 0, "R11 no late launch", busy, 0);

    // R6: supply drop
    frame(3, '0, 1'b1);
    pwr_good = 0;
    @(negedge clk);
    chk(busy === 0 && deep_pd === 0, "R6 supply drop idles", busy, 0);
    pwr_good = 1;
    frame(1, 17'h00500, 1'b1);
    chk(busy === 0, "R6 restart delay", busy, 0);
    repeat (PUW + 2) @(negedge clk);
    op_check(1, 17'h00600, "R6 after delay R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule